// File: doc/BRIEF.md
# RTC Frequency Trim Unit

This block sits between the enable pulses of a 32768 Hz oscillator and the prescaler of a real-time clock. It corrects the long-term rate of those pulses by a programmable signed amount: it removes single input enables when the oscillator runs fast, and it inserts single extra enables when the oscillator runs slow. The corrected pulse stream leaves on `tick_en` and feeds the prescaler in place of the raw oscillator enable.

The correction is held in one 16-bit register on a simple register port at address 0x18. The low byte is a two's complement step count from -128 to +127. Bit 15 selects the step size. When bit 15 is clear, a fine step of about 954 ppb applies, which is one cycle in a window of 2^FINE_LOG2 enables. When bit 15 is set, a coarse step of about 3815 ppb applies, which is one cycle in a window of 2^COARSE_LOG2 enables. Bits 14:8 hold a sign-dependent pattern that software must write as {0, ~S, S, S, S, S, S}, where S is the sign of the offset. The pattern is stored and read back, but it does not steer the correction. Reset loads 0x2000, which is the zero-offset fine setting.

Inside a window the correction points are spread evenly by an error accumulator. A write to the register is picked up at the next window boundary, and the window restarts there.

Top module: `rtc_trim`

## Requirements
- R1: After a synchronous active-low reset, the register at 0x18 reads 0x2000, `tick_en` is low, and the first window uses zero correction.
- R2: A write to address 0x18 stores all 16 bits, and a read of 0x18 returns them exactly. A write to any other address leaves the register unchanged, and a read of any other address returns 0.
- R3: With a zero offset, every input enable produces exactly one `tick_en` pulse, and no other pulses occur.
- R4: With a negative offset o in fine mode, a window of 2^FINE_LOG2 input enables yields exactly 2^FINE_LOG2 + o pulses. Each pulse that is removed is an input enable that is suppressed, and no extra pulses appear.
- R5: With a positive offset o, a window yields exactly window + o pulses. Each extra pulse appears in the first cycle without an input enable that follows a correction point.
- R6: When bit 15 is set, the window is 2^COARSE_LOG2 input enables and the correction is o cycles per window.
- R7: A register write takes effect only at the next window boundary. The window that is running when the write arrives keeps its previous setting.
- R8: An input enable that is kept appears on `tick_en` exactly one clock later.
- R9: Bits 14:8 have no effect on the correction.
- R10: The extreme offsets -128 and +127 give exactly 128 removed or 127 added pulses per window, in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_en | input | 1 | One-cycle enable from the 32768 Hz oscillator |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data, combinational from `addr` |
| tick_en | output | 1 | Corrected enable to the prescaler |

## Verification
A kept enable shows on `tick_en` one clock after the cycle in which `osc_en` is sampled. An inserted pulse shows two clocks after the enable that carries the correction point. A write is visible on `rdata` in the cycle after the write edge, and it affects the pulse count only from the next window on. The bench drives one enable every four cycles and samples `tick_en` at the falling edge after each of the four rising edges. This lets it check slot by slot that a kept pulse falls in the first sample, that an inserted pulse falls only in the second, and that the last two samples stay low. It also compares each window's total pulse count with the window length plus the offset that was active when the window began.

// File: rtl/rtc_trim_pkg.sv
// Package: shared register layout and helpers for the RTC frequency trim unit.
// Assumes the register is 16 bits wide with the offset in the low byte.
package rtc_trim_pkg;

    typedef struct packed {
        logic       coarse;   // step size select
        logic [6:0] pattern;  // sign pattern, stored only
        logic [7:0] offset;   // two's complement step count
    } trim_cfg_t;

    localparam logic [15:0] TRIM_NOMINAL = 16'h2000;

    // Magnitude of a signed byte; -128 maps to 128.
    function automatic logic [7:0] trim_mag(input logic [7:0] o);
        return o[7] ? (~o + 8'd1) : o;
    endfunction

endpackage

// File: rtl/rtc_trim_regs.sv
// Module: correction register with its read and write decode.
// Assumes single-cycle writes and a combinational read path.
module rtc_trim_regs #(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic [15:0]       trim_q
);
    import rtc_trim_pkg::*;

    logic hit;
    assign hit = (addr == REG_ADDR);

    // Store the full word on a write that matches the address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            trim_q <= TRIM_NOMINAL;
        else if (wr_en && hit)
            trim_q <= wdata;
    end

    // Return the register on a match and zero otherwise.
    always_comb begin
        rdata = hit ? trim_q : 16'h0000;
    end

endmodule

// File: rtl/rtc_trim_window.sv
// Module: window counter and correction point scheduler.
// It latches the register at each window boundary. An accumulator spreads
// |offset| correction points evenly over the enables of the window.
// Assumes COARSE_LOG2 <= FINE_LOG2 and COARSE_LOG2 >= 8.
module rtc_trim_window #(
    parameter int FINE_LOG2   = 20,
    parameter int COARSE_LOG2 = 18,
    localparam int CNT_W      = FINE_LOG2,
    localparam int ACC_W      = FINE_LOG2 + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_en,
    input  logic [15:0]      trim_q,
    output logic             fire,
    output logic             neg,
    output logic             boundary,
    output logic [15:0]      act_q,
    output logic [CNT_W-1:0] win_cnt
);
    import rtc_trim_pkg::*;

    localparam logic [ACC_W-1:0] FINE_SIZE   = ACC_W'(1) << FINE_LOG2;
    localparam logic [ACC_W-1:0] COARSE_SIZE = ACC_W'(1) << COARSE_LOG2;
    localparam logic [CNT_W-1:0] FINE_LAST   = CNT_W'(FINE_SIZE - ACC_W'(1));
    localparam logic [CNT_W-1:0] COARSE_LAST = CNT_W'(COARSE_SIZE - ACC_W'(1));

    trim_cfg_t        act;
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] win_size;
    logic [CNT_W-1:0] win_last;
    logic [ACC_W-1:0] mag;
    logic [ACC_W-1:0] sum;

    assign act = trim_cfg_t'(act_q);

    // Select the window length and find the correction points.
    always_comb begin
        win_size = act.coarse ? COARSE_SIZE : FINE_SIZE;
        win_last = act.coarse ? COARSE_LAST : FINE_LAST;
        mag      = ACC_W'(trim_mag(act.offset));
        sum      = acc + mag;
        fire     = osc_en && (sum >= win_size);
        neg      = act.offset[7];
        boundary = osc_en && (win_cnt == win_last);
    end

    // Advance the window on each enable and restart it at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt <= '0;
            acc     <= '0;
            act_q   <= TRIM_NOMINAL;
        end else if (boundary) begin
            win_cnt <= '0;
            acc     <= '0;
            act_q   <= trim_q;
        end else if (osc_en) begin
            win_cnt <= win_cnt + CNT_W'(1);
            acc     <= fire ? (sum - win_size) : sum;
        end
    end

endmodule

// File: rtl/rtc_trim_emit.sv
// Module: output pulse generator.
// It drops an enable at a negative correction point. It holds one pending
// extra pulse for a positive correction point and emits it in the next
// idle cycle. Assumes correction points are at least two enables apart.
module rtc_trim_emit (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_en,
    input  logic fire,
    input  logic neg,
    output logic tick_en,
    output logic pend
);

    // Register the corrected enable and track the pending insertion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_en <= 1'b0;
            pend    <= 1'b0;
        end else if (osc_en) begin
            tick_en <= !(fire && neg);
            pend    <= pend || (fire && !neg);
        end else begin
            tick_en <= pend;
            pend    <= 1'b0;
        end
    end

endmodule

// File: rtl/rtc_trim.sv
// Module: top of the RTC frequency trim unit.
// It joins the register, the window scheduler and the pulse generator.
// Assumes osc_en is a one-cycle pulse with idle cycles between pulses.
module rtc_trim #(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR    = 8'h18,
    parameter int                FINE_LOG2   = 20,
    parameter int                COARSE_LOG2 = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic              tick_en
);
    localparam int CNT_W = FINE_LOG2;

    logic [15:0]      trim_q;
    logic [15:0]      act_q;
    logic             fire;
    logic             neg;
    logic             boundary;
    logic             pend;
    logic [CNT_W-1:0] win_cnt;

    rtc_trim_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .trim_q(trim_q)
    );

    rtc_trim_window #(.FINE_LOG2(FINE_LOG2), .COARSE_LOG2(COARSE_LOG2)) u_win (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .trim_q(trim_q),
        .fire(fire), .neg(neg), .boundary(boundary), .act_q(act_q),
        .win_cnt(win_cnt)
    );

    rtc_trim_emit u_emit (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .fire(fire),
        .neg(neg), .tick_en(tick_en), .pend(pend)
    );

endmodule

// File: rtl/rtc_trim_chk.sv
// Checker: timing and state properties of the trim unit, bound to the top.
// Assumes it is attached through the bind statement at the end of this file.
module rtc_trim_chk #(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR    = 8'h18,
    parameter int                FINE_LOG2   = 20,
    parameter int                COARSE_LOG2 = 18
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 osc_en,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    addr,
    input logic                 tick_en,
    input logic [15:0]          trim_q,
    input logic [15:0]          act_q,
    input logic                 boundary,
    input logic [FINE_LOG2-1:0] win_cnt
);
    logic [1:0] cyc;
    logic       rst_seen;

    // Count clock cycles since reset, saturating at three.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc      <= 2'd0;
            rst_seen <= 1'b1;
        end else if (cyc != 2'd3) begin
            cyc <= cyc + 2'd1;
        end
    end

    // Check the register value in the first cycle after reset.
    always @(posedge clk) begin
        if (rst_seen && rst_n && cyc == 2'd0)
            AST_RESET_VALUE: assert (trim_q == 16'h2000 && act_q == 16'h2000); // R1
    end

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc != 2'd0 && !(wr_en && addr == REG_ADDR)) |=> $stable(trim_q)); // R2

    AST_KEEP_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_en && !act_q[7]) |=> tick_en); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        win_cnt <= (act_q[15] ? FINE_LOG2'((1 << COARSE_LOG2) - 1)
                              : FINE_LOG2'((1 << FINE_LOG2) - 1))); // R6

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc != 2'd0 && !boundary) |=> $stable(act_q)); // R7

    AST_EXTRA_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3 && tick_en && !$past(osc_en)) |-> $past(osc_en, 2)); // R5

endmodule

bind rtc_trim rtc_trim_chk #(
    .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR),
    .FINE_LOG2(FINE_LOG2), .COARSE_LOG2(COARSE_LOG2)
) u_chk (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .wr_en(wr_en), .addr(addr),
    .tick_en(tick_en), .trim_q(trim_q), .act_q(act_q),
    .boundary(boundary), .win_cnt(win_cnt)
);

// File: tb/rtc_trim_test.sv
`timescale 1ns/1ps
// Bench: directed and seeded random windows for the trim unit.
module rtc_trim_test;
    localparam int F = 10;
    localparam int C = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        osc_en;
    logic        wr_en;
    logic [7:0]  addr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic        tick_en;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    logic [15:0] cfg_next;
    logic [15:0] cfg_act;

    always #2.5 clk = ~clk;

    rtc_trim #(.FINE_LOG2(F), .COARSE_LOG2(C)) uut (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .tick_en(tick_en)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Build a register word with the sign pattern in bits 14:8.
    function automatic logic [15:0] make_cfg(input bit coarse, input int off);
        logic [7:0] o;
        o = 8'(off);
        return {coarse, 1'b0, ~o[7], {5{o[7]}}, o};
    endfunction

    function automatic int win_len(input logic [15:0] cfg);
        return cfg[15] ? (1 << C) : (1 << F);
    endfunction

    function automatic int exp_ticks(input logic [15:0] cfg);
        return win_len(cfg) + int'($signed(cfg[7:0]));
    endfunction

    // Run one window of enables, with a write of wv at slot wr_slot.
    task automatic run_window(input int wr_slot, input logic [15:0] wv, input string req);
        int cnt;
        int w;
        bit fail_slot;
        cnt = 0;
        fail_slot = 0;
        cfg_act = cfg_next;
        w = win_len(cfg_act);
        for (int s = 0; s < w; s++) begin
            osc_en = 1'b1;
            for (int k = 0; k < 4; k++) begin
                @(posedge clk);
                @(negedge clk);
                cnt += int'(tick_en);
                if (k == 0) begin
                    osc_en = 1'b0;
                    if (!cfg_act[7] && !tick_en) fail_slot = 1; // R8 kept enable one clock later
                    if (s == wr_slot) begin
                        wr_en = 1'b1; addr = 8'h18; wdata = wv;
                    end
                end else if (k == 1) begin
                    if (cfg_act[7] && tick_en) fail_slot = 1; // R4 no insertions when negative
                    if (wr_en) begin
                        wr_en = 1'b0;
                    end
                end else if (tick_en) begin
                    fail_slot = 1; // R5 insertions only right after the enable
                end
            end
        end
        check(!fail_slot, {req, " R8 R5 slot timing"}, int'(fail_slot), 0);
        check(cnt == exp_ticks(cfg_act), req, cnt, exp_ticks(cfg_act));
        if (wr_slot >= 0 && wr_slot < w - 1) cfg_next = wv;
        else cfg_next = cfg_act;
        if (wr_slot >= 0 && wr_slot < w - 1) cfg_next = wv;
    endtask

    initial begin
        logic [15:0] v;
        void'($urandom(32'd4242));
        rst_n = 1'b0; osc_en = 1'b0; wr_en = 1'b0; addr = 8'h18; wdata = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rdata == 16'h2000, "R1 reset value", rdata, 16'h2000);
        check(tick_en == 1'b0, "R1 tick low after reset", tick_en, 0);

        // R2: other addresses are ignored, 0x18 stores every bit.
        addr = 8'h10; wdata = 16'h1234; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        check(rdata == 16'h0000, "R2 other address reads zero", rdata, 0);
        addr = 8'h18; #1;
        check(rdata == 16'h2000, "R2 other address write ignored", rdata, 16'h2000);
        wdata = 16'hA5C3; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        check(rdata == 16'hA5C3, "R2 read back all bits", rdata, 16'hA5C3);
        wdata = 16'h2000; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        cfg_next = 16'h2000;

        // R1 R3 R7: first window is nominal although a write arrives mid-window.
        run_window(10, make_cfg(0, -5), "R1 R3 R7 nominal window");
        run_window(20, make_cfg(0, 7), "R4 fine -5");
        run_window(5, make_cfg(0, -128), "R5 fine +7");
        run_window(5, make_cfg(0, 127), "R10 fine -128");
        run_window(5, make_cfg(1, -128), "R10 fine +127");
        run_window(5, make_cfg(1, 127), "R6 R10 coarse -128");
        run_window(5, make_cfg(1, 3), "R6 R10 coarse +127");
        v = make_cfg(0, 4);
        v[14:8] = 7'h55;
        run_window(5, v, "R6 coarse +3");
        run_window(5, make_cfg(0, 0), "R9 odd pattern +4");
        addr = 8'h18; #1;
        check(rdata == 16'h2000, "R2 read back after windows", rdata, 16'h2000);
        for (int i = 0; i < 6; i++) begin
            int o;
            bit md;
            o  = int'($urandom_range(255)) - 128;
            md = 1'($urandom_range(1));
            v  = make_cfg(md, o);
            v[14:8] = 7'($urandom);
            run_window(int'($urandom_range(100)), v, "R3 R4 R5 R6 random");
        end
        run_window(-1, 16'h2000, "R3 R4 R5 R6 random last");

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule